// File: doc/BRIEF.md
# I2C Slave Transmitter with Status Codes

This block is the transmit half of a byte-oriented I2C slave. It watches the open-drain clock and data lines through synchronizers, finds START and STOP conditions, and collects the first byte after each START. When the upper seven bits of that byte equal the programmed own address, the direction bit is 1 (read) and the acknowledge-enable input is high, it acknowledges. It then returns data bytes to the master, most significant bit first. Each byte comes from a data register that the host writes before releasing the bus.

Every transfer event raises an interrupt flag and loads an 8-bit status code. While the flag is up, the block holds SCL low, so the master waits until the host has loaded the next byte and pulsed the clear input. If the host drops acknowledge-enable before it releases a byte, that byte becomes the last one. The block sends it, reports the outcome, and then leaves the bus, so any further reads by the master return all ones. An input strobe models entry into slave transmit after a lost arbitration as a master.

Top module: `i2c_slave_xmit`

## Requirements
- R1: After reset the status output reads F8h, the interrupt flag is low, and neither SCL nor SDA is pulled low.
- R2: A first byte after START whose bits 7..1 equal `ownAddr` and whose bit 0 is 1, received while `ackEnable` is high, is acknowledged by pulling SDA low during the ninth clock. At the falling edge that ends the ninth clock, the flag rises with status A8h.
- R3: Any other first byte (a different address, or the own address with bit 0 = 0) gets no acknowledge. The flag stays low and the status stays F8h.
- R4: The loaded byte is sent most significant bit first. SDA changes only while SCL is low, so each bit is stable over the whole high phase.
- R5: A byte acknowledged by the master while `ackEnable` was high at release gives status B8h, and the block stays addressed for the next byte.
- R6: A byte not acknowledged by the master gives status C0h. The block becomes not addressed, and later clocks from the master read ones with no flag raised.
- R7: A byte released while `ackEnable` is low is the last one. If the master acknowledges it, the status is C8h, the block becomes not addressed, and further reads return FFh.
- R8: While `ackEnable` is low the own address is not acknowledged. Once it is high again, the next START with the own address is acknowledged.
- R9: A pulse on `arbLost` while not addressed raises the flag with status B0h. The byte loaded before the flag is cleared is then transmitted.
- R10: While the flag is set, SCL is held low. A pulse on `irqClear` drops the flag and releases SCL, and the status then reads F8h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclDriveLow | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaDriveLow | output | 1 | 1 pulls SDA low |
| ownAddr | input | 7 | Own 7-bit slave address |
| ackEnable | input | 1 | Acknowledge-enable control |
| dataWr | input | 1 | Write strobe for the data register |
| dataWrVal | input | 8 | Byte written to the data register |
| irqClear | input | 1 | Pulse that clears the interrupt flag |
| arbLost | input | 1 | Pulse: entered slave transmit after losing arbitration |
| irqFlag | output | 1 | Interrupt flag |
| status | output | 8 | Status code, F8h while the flag is low |

## Verification
The hardest condition to reach from the ports is a byte released with `ackEnable` low that the master then acknowledges, followed by more reads from the master. Reaching it needs a complete addressed read, one serviced B8h event, a change of the control input while SCL is stretched, and a master that keeps clocking after C8h. The bench plays a bit-level master on wired-AND lines and steps through that exact sequence. It checks that the extra byte reads FFh and raises no flag. The same master also sweeps every 7-bit address and streams all 256 data values through one transfer.

// File: rtl/sxmt_pkg.sv
package sxmt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [BYTE_W-1:0] CODE_NONE      = 8'hF8;
  localparam logic [BYTE_W-1:0] CODE_ADDRESSED = 8'hA8;
  localparam logic [BYTE_W-1:0] CODE_ARBLOST   = 8'hB0;
  localparam logic [BYTE_W-1:0] CODE_SENT_ACK  = 8'hB8;
  localparam logic [BYTE_W-1:0] CODE_SENT_NACK = 8'hC0;
  localparam logic [BYTE_W-1:0] CODE_LAST_ACK  = 8'hC8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_LOAD, ST_TXBIT, ST_TACK
  } sxState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic shLoad;
    logic shIn;
    logic shOut;
  } dpCtl_t;
endpackage

// File: rtl/sxmt_datapath.sv
module sxmt_datapath
  import sxmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] dataWrVal,
  input  dpCtl_t            ctl,
  output logic              sclSync,
  output logic              sdaSync,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] shReg
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic [BYTE_W-1:0] dataReg;

  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : gSyncMany
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclSync = sclPipe[SYNC_STAGES-1];
  assign sdaSync = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;

  always_ff @(posedge clk) begin
    if (!rstN) dataReg <= '0;
    else if (dataWr) dataReg <= dataWrVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '1;
      bitCnt <= '0;
    end else begin
      if (ctl.shLoad)     shReg <= dataReg;
      else if (ctl.shIn)  shReg <= {shReg[BYTE_W-2:0], sdaSync};
      else if (ctl.shOut) shReg <= {shReg[BYTE_W-2:0], 1'b1};
      if (ctl.cntClr)      bitCnt <= '0;
      else if (ctl.cntInc) bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sxmt_control.sv
module sxmt_control
  import sxmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclSync,
  input  logic              sdaSync,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] shReg,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              ackEnable,
  input  logic              irqClear,
  input  logic              arbLost,
  output dpCtl_t            ctl,
  output logic              irqFlag,
  output logic [BYTE_W-1:0] codeReg,
  output logic              sdaDriveLow,
  output logic              sclDriveLow
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  sxState_t state, nextState;
  logic setFlag, lastByte, ackSeen, addrHit;
  logic [BYTE_W-1:0] setCode;

  assign addrHit = (shReg[BYTE_W-1:1] == ownAddr) && shReg[0] && ackEnable;

  always_comb begin
    nextState = state;
    ctl       = '0;
    setFlag   = 1'b0;
    setCode   = codeReg;
    if (stopDet) begin
      nextState = ST_IDLE;
    end else if (startDet) begin
      nextState  = ST_ADDR;
      ctl.cntClr = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (arbLost) begin
            setFlag   = 1'b1;
            setCode   = CODE_ARBLOST;
            nextState = ST_LOAD;
          end
        end
        ST_ADDR: begin
          if (arbLost) begin
            setFlag   = 1'b1;
            setCode   = CODE_ARBLOST;
            nextState = ST_LOAD;
          end else if (sclRise) begin
            ctl.shIn   = 1'b1;
            ctl.cntInc = 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            nextState = addrHit ? ST_AACK : ST_IDLE;
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            setFlag   = 1'b1;
            setCode   = CODE_ADDRESSED;
            nextState = ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (irqClear && irqFlag) begin
            ctl.shLoad = 1'b1;
            ctl.cntClr = 1'b1;
            nextState  = ST_TXBIT;
          end
        end
        ST_TXBIT: begin
          if (sclRise) begin
            ctl.cntInc = 1'b1;
          end else if (sclFall) begin
            if (bitCnt == FULL) nextState = ST_TACK;
            else ctl.shOut = 1'b1;
          end
        end
        ST_TACK: begin
          if (sclFall) begin
            setFlag = 1'b1;
            if (!ackSeen) begin
              setCode   = CODE_SENT_NACK;
              nextState = ST_IDLE;
            end else if (lastByte) begin
              setCode   = CODE_LAST_ACK;
              nextState = ST_IDLE;
            end else begin
              setCode   = CODE_SENT_ACK;
              nextState = ST_LOAD;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      irqFlag  <= 1'b0;
      codeReg  <= CODE_NONE;
      lastByte <= 1'b0;
      ackSeen  <= 1'b0;
    end else begin
      state <= nextState;
      if (setFlag) begin
        irqFlag <= 1'b1;
        codeReg <= setCode;
      end else if (irqClear) begin
        irqFlag <= 1'b0;
      end
      if (ctl.shLoad) lastByte <= ~ackEnable;
      if (state == ST_TACK && sclRise) ackSeen <= ~sdaSync;
    end
  end

  assign sclDriveLow = irqFlag;
  assign sdaDriveLow = (state == ST_AACK) || (state == ST_TXBIT && !shReg[BYTE_W-1]);

  // R2 and R8: acknowledge only for own address, read bit and enable set
  assert_ack_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_AACK && $past(state) == ST_ADDR) |->
      ($past(shReg[BYTE_W-1:1]) == ownAddr && $past(shReg[0]) && $past(ackEnable)));

  assert_sda_scl_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDriveLow != $past(sdaDriveLow) && !$past(startDet) && !$past(stopDet)) |->
      !$past(sclSync));

  assert_nack_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TACK && sclFall && !startDet && !stopDet && !ackSeen) |=>
      (state == ST_IDLE && codeReg == CODE_SENT_NACK && irqFlag));

  assert_last_byte_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TACK && sclFall && !startDet && !stopDet && ackSeen && lastByte) |=>
      (state == ST_IDLE && codeReg == CODE_LAST_ACK));

  assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> ($past(sclFall) || $past(arbLost)));

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !sclFall && !arbLost) |=> !irqFlag);
endmodule

// File: rtl/i2c_slave_xmit.sv
module i2c_slave_xmit
  import sxmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              ackEnable,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] dataWrVal,
  input  logic              irqClear,
  input  logic              arbLost,
  output logic              irqFlag,
  output logic [BYTE_W-1:0] status
);
  dpCtl_t ctl;
  logic sclSync, sdaSync, sclRise, sclFall, startDet, stopDet;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shReg, codeReg;

  sxmt_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .dataWr(dataWr), .dataWrVal(dataWrVal), .ctl(ctl),
    .sclSync(sclSync), .sdaSync(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .bitCnt(bitCnt), .shReg(shReg)
  );

  sxmt_control u_ctl (
    .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaSync(sdaSync),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .bitCnt(bitCnt), .shReg(shReg), .ownAddr(ownAddr), .ackEnable(ackEnable),
    .irqClear(irqClear), .arbLost(arbLost), .ctl(ctl), .irqFlag(irqFlag),
    .codeReg(codeReg), .sdaDriveLow(sdaDriveLow), .sclDriveLow(sclDriveLow)
  );

  assign status = irqFlag ? codeReg : CODE_NONE;

  assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag |-> (status == CODE_ADDRESSED || status == CODE_ARBLOST ||
                 status == CODE_SENT_ACK  || status == CODE_SENT_NACK ||
                 status == CODE_LAST_ACK));
endmodule

// File: tb/i2c_slave_xmit_tb.sv
`timescale 1ns/1ps
module i2c_slave_xmit_tb;
  localparam int HP = 6;
  localparam logic [6:0] OWN = 7'h5B;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic ackEnable = 1'b1, dataWr = 1'b0, irqClear = 1'b0, arbLost = 1'b0;
  logic [7:0] dataWrVal = 8'h00;
  logic sclDriveLow, sdaDriveLow, irqFlag;
  logic [7:0] status;
  wire sclLine = mScl & ~sclDriveLow;
  wire sdaLine = mSda & ~sdaDriveLow;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  i2c_slave_xmit u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .ownAddr(OWN),
    .ackEnable(ackEnable), .dataWr(dataWr), .dataWrVal(dataWrVal),
    .irqClear(irqClear), .arbLost(arbLost), .irqFlag(irqFlag), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclHigh();
    mScl = 1'b1;
    @(negedge clk);
    while (!sclLine) @(negedge clk);
  endtask

  task automatic bitXfer(input logic b, output logic seen);
    mSda = b;
    waitN(HP);
    sclHigh();
    waitN(HP);
    seen = sdaLine;
    mScl = 1'b0;
    waitN(4);
  endtask

  task automatic busStart();
    mSda = 1'b1;
    waitN(HP);
    sclHigh();
    waitN(HP);
    mSda = 1'b0;
    waitN(HP);
    mScl = 1'b0;
    waitN(4);
  endtask

  task automatic busStop();
    mSda = 1'b0;
    waitN(HP);
    sclHigh();
    waitN(HP);
    mSda = 1'b1;
    waitN(HP);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bitXfer(b[i], s);
    bitXfer(1'b1, s);
    acked = ~s;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] v);
    logic s1, s;
    for (int i = 7; i >= 0; i--) begin
      mSda = 1'b1;
      waitN(HP);
      sclHigh();
      waitN(2);
      s1 = sdaLine;
      waitN(HP - 2);
      chk("R4 bit stable while SCL high", sdaLine, s1);
      v[i] = s1;
      mScl = 1'b0;
      waitN(4);
    end
    bitXfer(~ackIt, s);
  endtask

  task automatic hostLoad(input logic [7:0] v);
    dataWrVal = v;
    dataWr = 1'b1;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic hostClear();
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
    @(negedge clk);
    chk("R10 flag low after clear", irqFlag, 1'b0);
    chk("R10 status F8 after clear", status, 8'hF8);
    chk("R10 SCL released after clear", sclDriveLow, 1'b0);
  endtask

  task automatic expectEvent(input string tag, input logic [7:0] code);
    waitN(2);
    chk(tag, status, code);
    chk("R10 flag set", irqFlag, 1'b1);
    chk("R10 SCL held low", sclDriveLow, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic acked;
    logic [7:0] got;
    waitN(10);
    chk("R1 status after reset", status, 8'hF8);
    chk("R1 flag after reset", irqFlag, 1'b0);
    chk("R1 SCL released", sclDriveLow, 1'b0);
    chk("R1 SDA released", sdaDriveLow, 1'b0);
    rstN = 1'b1;
    waitN(4);

    // R3: own address with write bit
    busStart();
    sendByte({OWN, 1'b0}, acked);
    chk("R3 write bit not acked", acked, 1'b0);
    waitN(2);
    chk("R3 no flag on write", irqFlag, 1'b0);
    busStop();

    // R2/R3: sweep every address with read bit
    for (int a = 0; a < 128; a++) begin
      busStart();
      sendByte({a[6:0], 1'b1}, acked);
      if (a[6:0] == OWN) begin
        chk("R2 own address acked", acked, 1'b1);
        expectEvent("R2 status A8", 8'hA8);
        hostLoad(8'h00);
        hostClear();
        readByte(1'b0, got);
        chk("R4 byte value", got, 8'h00);
        expectEvent("R6 status C0", 8'hC0);
        hostClear();
      end else begin
        chk("R3 other address not acked", acked, 1'b0);
        waitN(2);
        chk("R3 no flag", irqFlag, 1'b0);
        chk("R3 status F8", status, 8'hF8);
      end
      busStop();
    end

    // R4/R5/R6: all 256 byte values in one read
    busStart();
    sendByte({OWN, 1'b1}, acked);
    chk("R2 acked", acked, 1'b1);
    expectEvent("R2 status A8", 8'hA8);
    for (int v = 0; v < 256; v++) begin
      hostLoad(v[7:0]);
      hostClear();
      readByte(v != 255, got);
      chk("R4 byte value MSB first", got, v[7:0]);
      if (v != 255) expectEvent("R5 status B8", 8'hB8);
      else expectEvent("R6 status C0", 8'hC0);
    end
    hostClear();
    readByte(1'b1, got);
    chk("R6 not addressed reads ones", got, 8'hFF);
    waitN(2);
    chk("R6 no flag after extra read", irqFlag, 1'b0);
    busStop();

    // R7: enable dropped before the last byte is released
    busStart();
    sendByte({OWN, 1'b1}, acked);
    expectEvent("R7 setup A8", 8'hA8);
    hostLoad(8'h3C);
    hostClear();
    readByte(1'b1, got);
    chk("R7 first byte", got, 8'h3C);
    expectEvent("R7 setup B8", 8'hB8);
    ackEnable = 1'b0;
    hostLoad(8'hC3);
    hostClear();
    readByte(1'b1, got);
    chk("R7 last byte still sent", got, 8'hC3);
    expectEvent("R7 status C8", 8'hC8);
    hostClear();
    readByte(1'b1, got);
    chk("R7 later read gives ones", got, 8'hFF);
    waitN(2);
    chk("R7 no flag after drop", irqFlag, 1'b0);
    chk("R7 status F8 after drop", status, 8'hF8);
    busStop();

    // R8: enable low ignores own address, high resumes
    busStart();
    sendByte({OWN, 1'b1}, acked);
    chk("R8 own address ignored", acked, 1'b0);
    waitN(2);
    chk("R8 no flag while disabled", irqFlag, 1'b0);
    busStop();
    ackEnable = 1'b1;
    busStart();
    sendByte({OWN, 1'b1}, acked);
    chk("R8 recognition resumes", acked, 1'b1);
    expectEvent("R8 status A8", 8'hA8);
    hostLoad(8'h81);
    hostClear();
    readByte(1'b0, got);
    chk("R8 byte after resume", got, 8'h81);
    expectEvent("R8 status C0", 8'hC0);
    hostClear();
    busStop();

    // R9: arbitration-lost entry
    busStart();
    sendByte({OWN ^ 7'h01, 1'b1}, acked);
    chk("R9 other address not acked", acked, 1'b0);
    arbLost = 1'b1;
    @(negedge clk);
    arbLost = 1'b0;
    expectEvent("R9 status B0", 8'hB0);
    hostLoad(8'h96);
    hostClear();
    readByte(1'b0, got);
    chk("R9 byte after arbitration loss", got, 8'h96);
    expectEvent("R9 status C0", 8'hC0);
    hostClear();
    busStop();

    waitN(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule